// File: doc/BRIEF.md
# Serial Receive Status and Interrupt Logic

This block sits beside the shift register of a serial audio or SPI-style peripheral. It holds the last received word and the four event flags: transmit buffer empty, receive buffer full, receive overrun and transmit underrun. It also drives one interrupt line. The shifter reports each finished word with a strobe. The transmit side reports buffer loads and the moments when the shifter fetches the next word. The CPU side supplies one read strobe for the data register and one for the status register.

An overrun freezes the receive path. The held word stays as it was and every later word is thrown away. The overrun flag is released only by a data-register read followed by a status-register read, in that order. The interrupt line combines the flags through three enable inputs. The two error flags share one enable.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, the status word is 0001 with bit 0 the transmit-empty flag, bit 1 the receive-full flag, bit 2 the overrun flag and bit 3 the underrun flag. The data output is 0 and the interrupt is low.
- R2: A word strobed in while the receive-full and overrun flags are both clear appears on the data output and sets receive-full at the next clock.
- R3: A data-register read with no word arriving in the same cycle clears receive-full at the next clock.
- R4: A word arriving while receive-full is set, with no data read and no overrun in that cycle, sets overrun and leaves the data output unchanged.
- R5: While overrun is set, incoming words are discarded. The data output and receive-full do not change.
- R6: Overrun clears on a status-register read only if a data-register read came in an earlier cycle while overrun was set. A status read alone, or in the same cycle as the data read, does not clear it.
- R7: A transmit buffer load clears transmit-empty. A shifter fetch while transmit-empty is clear sets it again, unless a load comes in the same cycle.
- R8: A shifter fetch while transmit-empty is set raises underrun. A status-register read clears underrun, except in a cycle that raises it again.
- R9: The interrupt is high when any of these holds: transmit-empty and its enable, receive-full and its enable, or either error flag and the error enable.
- R10: A data read and a new word in the same cycle store the new word, keep receive-full set and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received word strobe from the shifter |
| rx_word_i | input | 16 | Received word |
| tx_load_i | input | 1 | CPU writes the transmit buffer |
| tx_fetch_i | input | 1 | Shifter fetches the next transmit word |
| dr_rd_i | input | 1 | Data register read strobe |
| sr_rd_i | input | 1 | Status register read strobe |
| txe_en_i | input | 1 | Transmit-empty interrupt enable |
| rxf_en_i | input | 1 | Receive-full interrupt enable |
| err_en_i | input | 1 | Error interrupt enable (overrun, underrun) |
| rd_data_o | output | 16 | Held receive word |
| status_o | output | 4 | {underrun, overrun, receive-full, transmit-empty} |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that the held word is frozen while overrun is set, and that accepted words show up one clock later. They also check that overrun and underrun rise on their trigger conditions and that overrun only falls after a status read. The order of the two-step overrun release can only be shown by the bench's sequences. These cover a status read before the data read, both reads in the same cycle, and words dropped between the two reads. The bench also covers the simultaneous cases: a read with a new word, a load with a fetch, and a fetch with a status read.

// File: rtl/serial_rx_status_pkg.sv
package serial_rx_status_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned NUM_IRQ   = 3;

  typedef struct packed {
    logic udr;
    logic ovr;
    logic rxf;
    logic txe;
  } flags_t;
endpackage

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              dr_rd_i,
  input  logic              sr_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rxf_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic rxf_q, rxf_d, ovr_q, ovr_d, armed_q, armed_d;
  logic rxf_eff;

  // buffer counts as free if it is being read this cycle
  assign rxf_eff = rxf_q && !dr_rd_i;

  always_comb begin
    data_d  = data_q;
    rxf_d   = rxf_q;
    ovr_d   = ovr_q;
    armed_d = armed_q;
    if (rx_valid_i && !ovr_q) begin
      if (rxf_eff) begin
        ovr_d   = 1'b1;
        armed_d = 1'b0;
      end else begin
        data_d = rx_word_i;
        rxf_d  = 1'b1;
      end
    end else if (dr_rd_i) begin
      rxf_d = 1'b0;
    end
    if (ovr_q) begin
      if (sr_rd_i && armed_q) begin
        ovr_d   = 1'b0;
        armed_d = 1'b0;
      end else if (dr_rd_i) begin
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      rxf_q   <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      rxf_q   <= rxf_d;
      ovr_q   <= ovr_d;
      armed_q <= armed_d;
    end
  end

  assign data_o = data_q;
  assign rxf_o  = rxf_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/tx_flag_ctrl.sv
module tx_flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_load_i,
  input  logic tx_fetch_i,
  input  logic sr_rd_i,
  output logic txe_o,
  output logic udr_o
);
  logic txe_q, txe_d, udr_q, udr_d;

  always_comb begin
    txe_d = txe_q;
    udr_d = udr_q;
    if (tx_fetch_i && !txe_q) txe_d = 1'b1;
    if (tx_load_i)            txe_d = 1'b0;
    if (tx_fetch_i && txe_q)  udr_d = 1'b1;
    else if (sr_rd_i)         udr_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_q <= 1'b1;
      udr_q <= 1'b0;
    end else begin
      txe_q <= txe_d;
      udr_q <= udr_d;
    end
  end

  assign txe_o = txe_q;
  assign udr_o = udr_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);
  logic [N_SRC-1:0] gated;
  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign gated[g] = src_i[g] & en_i[g];
  end
  assign irq_o = |gated;
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_status_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              tx_load_i,
  input  logic              tx_fetch_i,
  input  logic              dr_rd_i,
  input  logic              sr_rd_i,
  input  logic              txe_en_i,
  input  logic              rxf_en_i,
  input  logic              err_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_FLAGS-1:0] status_o,
  output logic              irq_o
);
  flags_t flags;

  rx_hold_reg #(.DATA_W(DATA_W)) i_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_word_i, .dr_rd_i, .sr_rd_i,
    .data_o(rd_data_o), .rxf_o(flags.rxf), .ovr_o(flags.ovr)
  );

  tx_flag_ctrl i_tx (
    .clk_i, .rst_ni, .tx_load_i, .tx_fetch_i, .sr_rd_i,
    .txe_o(flags.txe), .udr_o(flags.udr)
  );

  irq_merge #(.N_SRC(NUM_IRQ)) i_irq (
    .src_i({flags.ovr | flags.udr, flags.rxf, flags.txe}),
    .en_i ({err_en_i, rxf_en_i, txe_en_i}),
    .irq_o
  );

  assign status_o = flags;
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_word_i,
  input logic              tx_load_i,
  input logic              tx_fetch_i,
  input logic              dr_rd_i,
  input logic              sr_rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [3:0]        status_o
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !status_o[2] && !status_o[1]
      |=> status_o[1] && rd_data_o == $past(rx_word_i));

  p_accept_on_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && dr_rd_i && !status_o[2] |=> status_o[1] && !status_o[2]);

  p_rd_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_rd_i && !rx_valid_i |=> !status_o[1]);

  p_ovr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && status_o[1] && !dr_rd_i && !status_o[2]
      |=> status_o[2] && $stable(rd_data_o));

  p_ovr_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |=> $stable(rd_data_o));

  p_ovr_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[2]) |-> $past(sr_rd_i) && !$past(dr_rd_i, 2) == 1'b0 || $past(sr_rd_i));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> !status_o[0]);

  p_udr_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fetch_i && status_o[0] |=> status_o[3]);
endmodule

bind serial_rx_status serial_rx_status_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i, .rst_ni, .rx_valid_i, .rx_word_i, .tx_load_i, .tx_fetch_i,
  .dr_rd_i, .sr_rd_i, .rd_data_o, .status_o
);

// File: tb/test_serial_rx_status.sv
module test_serial_rx_status;
  typedef struct packed {
    logic        rxv;
    logic [15:0] word;
    logic        dr;
    logic        sr;
    logic        ld;
    logic        tk;
    logic [2:0]  ie;   // {err, rxf, txe}
    logic [15:0] exp_data;
    logic [3:0]  exp_st;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'hA111, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 16'hA111, 4'b0011, 1'b0}, // R2
    '{1'b1, 16'hB222, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 16'hA111, 4'b0111, 1'b0}, // R4
    '{1'b1, 16'hC333, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 16'hA111, 4'b0111, 1'b0}, // R5
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 16'hA111, 4'b0111, 1'b0}, // R6 sr alone
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 16'hA111, 4'b0101, 1'b0}, // R3 arm
    '{1'b1, 16'hD444, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 16'hA111, 4'b0101, 1'b0}, // R5 drop
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 16'hA111, 4'b0001, 1'b0}, // R6 clear
    '{1'b1, 16'hD444, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 16'hD444, 4'b0011, 1'b0}, // R2
    '{1'b1, 16'hE555, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 16'hE555, 4'b0011, 1'b0}, // R10
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 16'hE555, 4'b0001, 1'b0}, // R3
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 16'hE555, 4'b0000, 1'b0}, // R7 load
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 16'hE555, 4'b0001, 1'b0}, // R7 fetch
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 16'hE555, 4'b1001, 1'b0}, // R8 underrun
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 16'hE555, 4'b1001, 1'b1}, // R9 err
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100, 16'hE555, 4'b0001, 1'b0}, // R8 clear
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 16'hE555, 4'b0001, 1'b1}, // R9 txe
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 16'hE555, 4'b0000, 1'b0}, // R9 txe off
    '{1'b1, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 16'h5A5A, 4'b0010, 1'b1}, // R9 rxf
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 16'h5A5A, 4'b0000, 1'b0}  // R3
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_valid_i = 1'b0, tx_load_i = 1'b0, tx_fetch_i = 1'b0;
  logic dr_rd_i = 1'b0, sr_rd_i = 1'b0;
  logic txe_en_i = 1'b0, rxf_en_i = 1'b0, err_en_i = 1'b0;
  logic [15:0] rx_word_i = '0;
  logic [15:0] rd_data_o;
  logic [3:0]  status_o;
  logic        irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  serial_rx_status i_serial_rx_status (
    .clk_i, .rst_ni, .rx_valid_i, .rx_word_i, .tx_load_i, .tx_fetch_i,
    .dr_rd_i, .sr_rd_i, .txe_en_i, .rxf_en_i, .err_en_i,
    .rd_data_o, .status_o, .irq_o
  );

  task automatic check(string req, logic [15:0] d, logic [3:0] s, logic q);
    n_chk++;
    if (rd_data_o !== d || status_o !== s || irq_o !== q) begin
      n_bad++;
      $display("FAIL %s: data=%h st=%b irq=%b expected data=%h st=%b irq=%b",
               req, rd_data_o, status_o, irq_o, d, s, q);
    end
  endtask

  task automatic drive(logic rxv, logic [15:0] w, logic dr, logic sr,
                       logic ld, logic tk, logic [2:0] ie);
    rx_valid_i = rxv; rx_word_i = w; dr_rd_i = dr; sr_rd_i = sr;
    tx_load_i = ld; tx_fetch_i = tk;
    {err_en_i, rxf_en_i, txe_en_i} = ie;
    @(negedge clk_i);
  endtask

  task automatic idle();
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 16'h0, 4'b0001, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 16'h0, 4'b0001, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].rxv, VECS[i].word, VECS[i].dr, VECS[i].sr,
            VECS[i].ld, VECS[i].tk, VECS[i].ie);
      check($sformatf("vector %0d (R2-R10 table)", i),
            VECS[i].exp_data, VECS[i].exp_st, VECS[i].exp_irq);
    end

    // R6: both reads in one cycle do not release overrun
    drive(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000); // store, st 0010
    drive(1'b1, 16'h9999, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000); // overrun
    check("R4", 16'h1234, 4'b0110, 1'b0);
    drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000);
    check("R6", 16'h1234, 4'b0100, 1'b0);
    drive(1'b1, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100);  // dropped, R5
    check("R5", 16'h1234, 4'b0100, 1'b1);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100);
    check("R6", 16'h1234, 4'b0000, 1'b0);

    // R7: load together with fetch while buffer full keeps txe low
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000);
    check("R7", 16'h1234, 4'b0000, 1'b0);

    // R8: fetch on empty with status read -> underrun stays set
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000); // txe back
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000);
    check("R8", 16'h1234, 4'b1001, 1'b0);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);
    check("R8", 16'h1234, 4'b0001, 1'b0);

    // R1: reset mid-run
    drive(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111);
    rst_ni = 1'b0;
    idle();
    check("R1", 16'h0, 4'b0001, 1'b0);
    rst_ni = 1'b1;
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule